// File: doc/BRIEF.md
# Serial PHY Management Master

This block is a serial management master for the registers of an Ethernet PHY. It takes one request at a time on a valid/ready interface. A request carries a read or write flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. The block sends the request as a serial frame on a divided management clock. The data line is split into an output, an output enable and an input, so that a tristate buffer outside the block can join them into a single bidirectional wire.

Each transaction starts with a run of ones that lets the PHY find bit sync, followed by the frame fields. A read releases the line for the two turnaround bits and for the sixteen data bits, and it samples the data on the rising edges of the management clock. A write drives the whole frame and then gives two more clock periods with the line released. When the transaction ends, the result appears on a valid/ready response port. While a response waits to be accepted, the block takes no new request. A new request is accepted in the same cycle in which the pending response is consumed.

The management clock runs only during a transaction and rests low otherwise. Its half period, counted in system clocks, is a parameter. With the default value and a 125 MHz system clock the rate is 2.5 MHz, which is the highest rate a PHY is required to accept.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc is 0, mdio_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: Every transaction starts with PRE_BITS (default 32) bit periods in which mdio_oe is 1 and mdio_o is 1.
- R3: A read sends, MSB first after the preamble, the 14 bits 01, 10, PHY address[4:0] and register address[4:0].
- R4: A read then holds mdio_oe at 0 for 18 bit periods: 2 turnaround bits and 16 data bits. The data bits are sampled from mdio_i at each MDC rising edge, MSB first, and are returned in rsp_rdata.
- R5: A write drives, MSB first after the preamble, the 32 bits 01, 01, PHY address, register address, 10 and data[15:0].
- R6: After the 32 write bits come two more MDC periods with mdio_oe at 0. Only after these does the response become valid.
- R7: A bit period lasts 2*HALF_DIV system clocks. mdc is low for the first HALF_DIV cycles and high for the second. Between transactions mdc stays low.
- R8: mdio_o and mdio_oe change only while mdc is low.
- R9: rsp_valid rises in the cycle after the last MDC falling edge. It stays high with rsp_rdata unchanged until a cycle with rsp_ready high. For a write, rsp_rdata is 0.
- R10: req_ready is 1 only when no transaction is in flight and either no response is pending or rsp_ready is 1. Request fields are captured at acceptance, and changes to them during a transaction have no effect on the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed when high together with rsp_valid |
| rsp_rdata | output | 16 | Read data (0 after a write) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Serial data in |

## Verification
Two events can fall in the same cycle: a pending response being consumed and a new request being accepted. The bench provokes this by holding rsp_ready low while a read result waits. In a single cycle it then raises rsp_ready and presents a new write. The behavioural model expects req_ready high in that cycle, rsp_valid low in the next cycle, and the preamble of the new write starting at once. During the hold it checks every cycle that the read data stays stable. The model also reverses the direction of the line in step with the read frame, and it scrambles the request fields while a transaction is in flight.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 32;
  localparam int HDR_BITS   = 14;
  localparam int TA_BITS    = 2;
  localparam int DATA_BITS  = 16;
  localparam int TAIL_BITS  = 2;

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] WR_TA    = 2'b10;

  typedef struct packed {
    logic        write;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mdio_req_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int HALF_DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_now,
  output logic fall_now
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = run && (cnt == LAST);
  assign rise_now = wrap && !mdc;
  assign fall_now = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_mdc_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mdc);
  p_mdc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && !$past(wrap) |-> $stable(mdc));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32,
  parameter int IDX_W    = 7
) (
  input  logic             active,
  input  mdio_req_t        req,
  input  logic [IDX_W-1:0] idx,
  output logic             bit_o,
  output logic             bit_oe,
  output logic             bit_sample,
  output logic [IDX_W-1:0] last_idx
);
  localparam logic [IDX_W-1:0] PRE_I  = IDX_W'(PRE_BITS);
  localparam logic [IDX_W-1:0] HDR_I  = IDX_W'(HDR_BITS);
  localparam logic [IDX_W-1:0] DAT0_I = IDX_W'(HDR_BITS + TA_BITS);
  localparam logic [IDX_W-1:0] FRM_I  = IDX_W'(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_R = IDX_W'(PRE_BITS + FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] LAST_W = IDX_W'(PRE_BITS + FRAME_BITS + TAIL_BITS - 1);

  logic [FRAME_BITS-1:0] word;
  logic [IDX_W-1:0]      f;
  logic [4:0]            pos;

  always_comb begin
    if (req.write)
      word = {SOF_CODE, OP_WR, req.phy, req.regad, WR_TA, req.wdata};
    else
      word = {SOF_CODE, OP_RD, req.phy, req.regad, 18'd0};
  end

  assign last_idx = req.write ? LAST_W : LAST_R;
  assign f        = idx - PRE_I;
  assign pos      = 5'(FRAME_BITS - 1) - f[4:0];

  always_comb begin
    bit_o      = 1'b0;
    bit_oe     = 1'b0;
    bit_sample = 1'b0;
    if (active) begin
      if (idx < PRE_I) begin
        bit_o  = 1'b1;
        bit_oe = 1'b1;
      end else if (f < FRM_I) begin
        bit_o      = word[pos];
        bit_oe     = req.write || (f < HDR_I);
        bit_sample = !req.write && (f >= DAT0_I);
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 25,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [15:0] rsp_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int IDX_W = $clog2(PRE_BITS + FRAME_BITS + TAIL_BITS + 1);

  logic             busy;
  logic [IDX_W-1:0] bit_idx;
  logic [IDX_W-1:0] last_idx;
  mdio_req_t        cur;
  logic             rise_now, fall_now, sample_bit;
  logic             accept;

  assign req_ready = !busy && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;

  mdio_clk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise_now(rise_now), .fall_now(fall_now)
  );

  mdio_frame #(.PRE_BITS(PRE_BITS), .IDX_W(IDX_W)) u_frame (
    .active(busy), .req(cur), .idx(bit_idx),
    .bit_o(mdio_o), .bit_oe(mdio_oe), .bit_sample(sample_bit),
    .last_idx(last_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      bit_idx   <= '0;
      cur       <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        bit_idx   <= '0;
        rsp_rdata <= '0;
        cur       <= '{write: req_write, phy: req_phy, regad: req_reg, wdata: req_wdata};
      end else if (busy) begin
        if (rise_now && sample_bit)
          rsp_rdata <= {rsp_rdata[14:0], mdio_i};
        if (fall_now) begin
          if (bit_idx == last_idx) begin
            busy      <= 1'b0;
            rsp_valid <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
      end
    end
  end

  p_out_change_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) || !$stable(mdio_oe) |-> !mdc);
  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
  p_released_at_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_now && sample_bit |-> !mdio_oe);
  p_rsp_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> !mdc && !busy);
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int HALF = 25;
  localparam int PRE  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic rsp_ready = 1'b1;
  logic mdio_i = 1'b1;
  logic req_ready, rsp_valid, mdc, mdio_o, mdio_oe;
  logic [15:0] rsp_rdata;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [15:0] phy_data = '0;

  always #4 clk = ~clk;

  mdio_master #(.HALF_DIV(HALF), .PRE_BITS(PRE)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model, compared on every clock at the falling edge
  initial begin
    bit active = 0, pending = 0, mwr = 0;
    int t = 0, nbits = 0;
    logic [31:0] word = '0;
    logic [15:0] mrd = '0, exp_rd = '0;
    logic prev_o = 0, prev_oe = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if ((mdio_o !== prev_o || mdio_oe !== prev_oe) && mdc)
          chk(0, "R8", "output changed while mdc high", {31'd0, mdio_o}, {31'd0, prev_o});
        if (active) begin
          if (t == nbits * 2 * HALF) begin
            chk(rsp_valid === 1'b1, "R9", "rsp_valid at end", {31'd0, rsp_valid}, 1);
            chk(rsp_rdata === exp_rd, mwr ? "R9" : "R4", "rsp_rdata", {16'd0, rsp_rdata}, {16'd0, exp_rd});
            chk(mdc === 1'b0, "R7", "mdc after end", {31'd0, mdc}, 0);
            chk(mdio_oe === 1'b0, "R6", "oe after end", {31'd0, mdio_oe}, 0);
            active = 0;
            pending = 1;
          end else begin
            int b, f;
            logic eo, eoe;
            string rq;
            b = t / (2 * HALF);
            f = b - PRE;
            chk(mdc === 1'((t / HALF) % 2), "R7", "mdc phase", {31'd0, mdc}, (t / HALF) % 2);
            chk(rsp_valid === 1'b0, "R9", "rsp_valid in flight", {31'd0, rsp_valid}, 0);
            if (b < PRE) begin eo = 1; eoe = 1; rq = "R2"; end
            else if (f < 32) begin
              eo = word[31 - f];
              eoe = mwr || (f < 14);
              rq = mwr ? "R5" : (f < 14 ? "R3" : "R4");
            end else begin eo = 0; eoe = 0; rq = "R6"; end
            chk(mdio_oe === eoe, rq, "mdio_oe", {31'd0, mdio_oe}, {31'd0, eoe});
            if (eoe) chk(mdio_o === eo, rq, "mdio_o", {31'd0, mdio_o}, {31'd0, eo});
            if (!mwr && f >= 16 && f < 32) mdio_i = mrd[15 - (f - 16)];
            else mdio_i = 1'b1;
            t++;
          end
        end else begin
          chk(mdc === 1'b0, "R7", "mdc idle", {31'd0, mdc}, 0);
          chk(mdio_oe === 1'b0, "R7", "oe idle", {31'd0, mdio_oe}, 0);
          chk(rsp_valid === pending, "R9", "rsp_valid hold", {31'd0, rsp_valid}, {31'd0, pending});
          if (pending) chk(rsp_rdata === exp_rd, "R9", "rsp_rdata hold", {16'd0, rsp_rdata}, {16'd0, exp_rd});
        end
        begin
          bit er;
          er = !active && (!pending || rsp_ready);
          chk(req_ready === er, "R10", "req_ready", {31'd0, req_ready}, {31'd0, er});
          if (pending && rsp_ready) pending = 0;
          if (req_valid && er) begin
            active = 1; t = 0; mwr = req_write; mrd = phy_data;
            if (req_write) begin
              word = {2'b01, 2'b01, req_phy, req_reg, 2'b10, req_wdata};
              nbits = PRE + 34; exp_rd = 16'd0;
            end else begin
              word = {2'b01, 2'b10, req_phy, req_reg, 18'd0};
              nbits = PRE + 32; exp_rd = phy_data;
            end
          end
        end
      end
      prev_o = mdio_o;
      prev_oe = mdio_oe;
    end
  end

  task automatic do_req(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wd, input logic [15:0] rd, input bit release_rsp);
    @(posedge clk); #1;
    req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
    phy_data = rd; req_valid = 1'b1;
    if (release_rsp) rsp_ready = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    // R10: scramble fields during the transaction; the model keeps the captured ones
    req_write = ~wr; req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;
  endtask

  task automatic wait_rsp();
    do @(negedge clk); while (!rsp_valid);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1", "reset outputs", {30'd0, mdc, mdio_oe}, 0);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R1", "reset handshake", {30'd0, req_ready, rsp_valid}, 2);
    do_req(1'b1, 5'h01, 5'h02, 16'hA5C3, 16'h0000, 1'b0);
    wait_rsp();
    do_req(1'b0, 5'h1F, 5'h1E, 16'h0000, 16'h8001, 1'b0);
    wait_rsp();
    @(posedge clk); #1 rsp_ready = 1'b0;
    do_req(1'b0, 5'h0A, 5'h05, 16'h1234, 16'h5A3C, 1'b0);
    wait_rsp();
    repeat (20) @(posedge clk);
    // coincident: consume the pending response and present a new write together
    do_req(1'b1, 5'h00, 5'h00, 16'hFFFF, 16'h0000, 1'b1);
    wait_rsp();
    do_req(1'b0, 5'h15, 5'h0A, 16'h0000, 16'h0000, 1'b0);
    wait_rsp();
    repeat (10) @(posedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule